// File: doc/BRIEF.md
# Phase-Shift-Keyed Subcarrier Load Modulator

This block drives the load-modulation switch of a passive tag that uses phase-shift keying. It runs directly on the recovered carrier clock, so one clock cycle is one carrier period. Outside bit boundaries the switch flips on every period, which forms a subcarrier at half the carrier rate. One data bit is sent every `BIT_PERIOD` carrier periods (16 by default). At each bit boundary the block either keeps toggling, which sends a 1, or holds the switch for one extra period, which shifts the subcarrier phase by 180 degrees and sends a 0.

A frame sequencer supplies the serial bits. One period before each boundary, the block raises a one-cycle request. The sequencer puts the next bit on `bit_i` during that cycle, and the block captures it at the closing edge of that cycle. The block drives a single switch output. This variant has only one coil-side switch.

Top module: `psk_load_mod`

## Requirements
- R1: While `rst_ni` is low, `mod_o` is 0 (switch OFF) and `req_o` is 0. Both take effect without waiting for a clock edge.
- R2: Counting rising edges after reset release as n = 1, 2, ..., every edge where n is not a multiple of `BIT_PERIOD` inverts `mod_o`.
- R3: `req_o` is 1 for exactly one cycle per bit interval. It is 1 in the cycle after edge n where n mod `BIT_PERIOD` = `BIT_PERIOD`-2, and 0 in all other cycles.
- R4: The value of `bit_i` at the edge that closes a `req_o` cycle is the next bit. If that bit is 0, `mod_o` keeps its value at the next boundary edge (n a multiple of `BIT_PERIOD`). This is the phase shift.
- R5: If the captured bit is 1, `mod_o` inverts at the boundary edge, so no phase shift occurs.
- R6: `bit_i` has no effect on `mod_o` in any cycle where `req_o` is 0.
- R7: The first bit boundary is edge n = `BIT_PERIOD` after reset release. A reset in mid-frame restarts this timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier clock, one cycle per carrier period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Next serial data bit from the frame sequencer |
| mod_o | output | 1 | Modulation switch control, 1 = ON |
| req_o | output | 1 | Next-bit request, one cycle before each boundary |

## Verification
The bench builds the block with the default `BIT_PERIOD` of 16, which gives the 16-period bit rate. With this value, runs of repeated zeros (consecutive phase shifts) and long runs of ones fit into a few hundred cycles. While `req_o` is low, the bench drives random values on `bit_i`, so any leak of data outside the request window shows up as a wrong switch state. A reset in mid-frame checks that the boundary timing and the OFF start state are re-established.

// File: rtl/psk_pkg.sv
package psk_pkg;
  typedef enum logic {
    PH_TOGGLE = 1'b0,
    PH_HOLD   = 1'b1
  } step_t;
endpackage

// File: rtl/psk_bit_timer.sv
module psk_bit_timer #(
  parameter int BIT_PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic req_o,
  output logic bnd_o
);
  localparam int CW     = $clog2(BIT_PERIOD);
  localparam int LAST   = BIT_PERIOD - 1;
  localparam int REQ_AT = BIT_PERIOD - 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q == CW'(LAST))      cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign req_o = (cnt_q == CW'(REQ_AT));
  assign bnd_o = (cnt_q == CW'(LAST));

  // R3
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R4
  req_then_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> bnd_o);
endmodule

// File: rtl/psk_bit_latch.sv
module psk_bit_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic bit_i,
  output logic bit_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bit_q <= 1'b1;
    else if (cap_i) bit_q <= bit_i;
  end

  assign bit_o = bit_q;

  // R4
  cap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> bit_q == $past(bit_i));
  // R6
  cap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(bit_q));
endmodule

// File: rtl/psk_phase_gen.sv
module psk_phase_gen
  import psk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  step_t step_i,
  output logic  sw_o
);
  logic sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sw_q <= 1'b0;
    else if (step_i == PH_TOGGLE) sw_q <= ~sw_q;
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/psk_load_mod.sv
module psk_load_mod
  import psk_pkg::*;
#(
  parameter int BIT_PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic mod_o,
  output logic req_o
);
  logic  req, bnd, bit_q;
  step_t step;

  psk_bit_timer #(.BIT_PERIOD(BIT_PERIOD)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_o (req),
    .bnd_o (bnd)
  );

  psk_bit_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (req),
    .bit_i (bit_i),
    .bit_o (bit_q)
  );

  // zero bit at a boundary: skip one toggle -> 180 degree subcarrier shift
  assign step = (bnd && !bit_q) ? PH_HOLD : PH_TOGGLE;

  psk_phase_gen u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .sw_o  (mod_o)
  );

  assign req_o = req;

  // R2
  mid_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> mod_o != $past(mod_o));
  // R4
  zero_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && !bit_q) |=> mod_o == $past(mod_o));
  // R5
  one_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && bit_q) |=> mod_o != $past(mod_o));
  // R1
  always_comb begin
    if (!rst_ni) begin
      rst_off_chk: assert (!mod_o || $isunknown(mod_o));
    end
  end
endmodule

// File: tb/tb_psk_load_mod.sv
module tb_psk_load_mod;
  localparam int BP = 16;
  localparam logic [47:0] PAT = 48'b1111_1111_1001_0110_0001_1010_0000_1101_1111_0100_1001_0011;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic mod_o, req_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit exp_q[$];
  int n;
  logic exp_mod;
  int pi = 0;

  always #4 clk = ~clk;

  psk_load_mod #(.BIT_PERIOD(BP)) dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .mod_o (mod_o),
    .req_o (req_o)
  );

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s n=%0d act=%0b exp=%0b", tag, n, act, exp);
    end
  endtask

  // driver pushes captured bit, monitor pops it at the boundary
  task automatic run(input int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      if (req_o === 1'b1) begin
        bit_i = PAT[47 - (pi % 48)];
        exp_q.push_back(bit_i);
        pi++;
      end else begin
        bit_i = 1'($urandom); // R6: noise outside request window
      end
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n % BP == 0) begin
        bit b;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 no request before boundary", 1'b0, 1'b1);
          b = 1'b1;
        end else b = exp_q.pop_front();
        if (!b) exp_mod = exp_mod;     // R4 hold
        else    exp_mod = ~exp_mod;    // R5 toggle
        chk(mod_o === exp_mod, b ? "R5 boundary one" : "R4 boundary zero (R7 timing)", mod_o, exp_mod);
      end else begin
        exp_mod = ~exp_mod;
        chk(mod_o === exp_mod, "R2 mid toggle (R6)", mod_o, exp_mod);
      end
      chk(req_o === ((n % BP) == BP - 2), "R3 request timing", req_o, logic'((n % BP) == BP - 2));
    end
  endtask

  initial begin
    n = 0;
    exp_mod = 1'b0;
    repeat (3) @(negedge clk);
    chk(mod_o === 1'b0, "R1 reset mod", mod_o, 1'b0);
    chk(req_o === 1'b0, "R1 reset req", req_o, 1'b0);
    rst_ni = 1'b1;
    run(BP * 30 + 5);
    // mid-frame reset
    rst_ni = 1'b0;
    #1;
    chk(mod_o === 1'b0, "R1 async reset mod", mod_o, 1'b0);
    chk(req_o === 1'b0, "R1 async reset req", req_o, 1'b0);
    exp_q.delete();
    repeat (2) @(negedge clk);
    n = 0;
    exp_mod = 1'b0;
    rst_ni = 1'b1;
    run(BP * 12); // R7 restart timing
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule